// File: doc/BRIEF.md
# Tree carry-lookahead adder

A purely combinational adder for two operands of a configurable width and a carry-in. It returns the sum and the carry-out in the same cycle. No carry ever ripples from one 4-bit group to the next. Each bit forms a propagate term (the XOR of its operand bits) and a generate term (their AND). Lookahead units with four inputs turn these terms into carries. Each unit also passes a combined propagate and generate up to a unit one level higher. That higher unit sends back the carry-in of every group below it. Levels are added until a single unit remains.

The width defaults to 16 and may be raised to 32, 64 or any value of at least 2. A level whose node count is not a multiple of four ends in a narrower unit. Some levels have a partial unit: 32 bits run through levels of 8, 2 and 1 nodes, and 6 bits through 2 and 1. The block is meant to sit inside an arithmetic datapath where the ripple delay of a long adder is too slow.

Top module: `cla_tree_adder`

## Requirements
- R1: `sum` equals the low `W` bits of the unsigned total `a + b + cin`.
- R2: `cout` equals bit `W` of the unsigned total `a + b + cin`.
- R3: With `b` all zeros and `cin` = 1, `{cout,sum}` equals `a + 1`, including the all-ones case where `sum` becomes zero and `cout` becomes 1.
- R4: When `a XOR b` is all ones, every bit propagates: `sum` is all ones if `cin` = 0 and all zeros if `cin` = 1, and `cout` equals `cin`.
- R5: When `a` equals `b`, `{cout,sum}` equals `a` shifted left by one with `cin` in bit 0.
- R6: With `b` all zeros and `cin` = 0, `sum` equals `a` and `cout` is 0; all-zero inputs give an all-zero result.
- R7: The rules above hold for every width parameter of at least 2. This includes widths that leave a partial unit in some level (6, 32) and widths needing three levels (64).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | W | First operand, unsigned |
| b | input | W | Second operand, unsigned |
| cin | input | 1 | Carry into bit 0 |
| sum | output | W | Low W bits of the total |
| cout | output | 1 | Carry out of bit W-1 |

## Verification
The bound checks are immediate and evaluated combinationally. They assume `a`, `b` and `cin` hold known values with no X or Z bits. They also assume the outputs are judged only once the inputs have stopped moving. The bench starts all operands at zero and changes them only on the rising clock edge. It compares outputs at the falling edge, half a period later, so every check sees settled, fully known values. The 6-bit instance is driven exhaustively. The 16-, 32- and 64-bit instances get directed carry-chain patterns and random operands.

// File: rtl/cla_tree_adder.sv
module cla_tree_adder #(
  parameter int W = 16
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);

  function automatic int lsize(int k);
    int n;
    n = W;
    for (int i = 0; i < k; i++) n = (n + 3) / 4;
    return n;
  endfunction

  function automatic int nlev();
    int k;
    k = 0;
    for (int i = 0; i < 40; i++) if (lsize(i) > 1) k = i + 1;
    return k;
  endfunction

  localparam int L = nlev();

  // two-level carry after n positions of a unit: OR of generate/carry-in terms
  // each ANDed with all propagates above them
  function automatic logic la(int n, logic [3:0] p, logic [3:0] g, logic c0);
    logic r, t;
    r = 1'b0;
    for (int j = 0; j <= 4; j++) begin
      if (j <= n) begin
        if (j == 0) t = c0;
        else        t = g[j-1];
        for (int k = 0; k < 4; k++) if (k >= j && k < n) t = t & p[k];
        r = r | t;
      end
    end
    return r;
  endfunction

  for (genvar k = 0; k < L; k++) begin : g_lvl
    localparam int NC = lsize(k);
    localparam int NU = lsize(k + 1);
    logic [NC-1:0] pi, gi, ci;
    logic [NU-1:0] po, go, pc;

    if (k == 0) begin : g_bits
      assign pi = a ^ b;
      assign gi = a & b;
    end else begin : g_up
      assign pi = g_lvl[k-1].po;
      assign gi = g_lvl[k-1].go;
      assign g_lvl[k-1].pc = ci;
    end

    if (k == L - 1) begin : g_root
      assign pc = cin;
    end

    for (genvar u = 0; u < NU; u++) begin : g_unit
      localparam int M = (NC - 4*u < 4) ? NC - 4*u : 4;
      logic [3:0] up, ug;
      for (genvar i = 0; i < 4; i++) begin : g_in
        if (i < M) begin : g_used
          assign up[i] = pi[4*u+i];
          assign ug[i] = gi[4*u+i];
          assign ci[4*u+i] = la(i, up, ug, pc[u]);
        end else begin : g_pad
          assign up[i] = 1'b0;
          assign ug[i] = 1'b0;
        end
      end
      assign po[u] = &up[M-1:0];
      assign go[u] = la(M, up, ug, 1'b0);
    end
  end

  assign sum  = g_lvl[0].pi ^ g_lvl[0].ci;
  assign cout = g_lvl[L-1].go[0] | (g_lvl[L-1].po[0] & cin);

endmodule

// File: rtl/cla_tree_adder_chk.sv
module cla_tree_adder_chk #(
  parameter int W = 16
) (
  input logic [W-1:0] a,
  input logic [W-1:0] b,
  input logic         cin,
  input logic [W-1:0] sum,
  input logic         cout
);

  logic [W:0] tot;
  assign tot = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};

  always_comb begin
    a_r1_sum_low: assert (sum == tot[W-1:0]);
    a_r2_carry_out: assert (cout == tot[W]);
    if (b == '0 && cin) begin
      a_r3_increment: assert ({cout, sum} == {1'b0, a} + {{W{1'b0}}, 1'b1});
    end
    if ((a ^ b) == '1) begin
      a_r4_full_propagate: assert (sum == {W{~cin}} && cout == cin);
    end
    if (a == b) begin
      a_r5_doubling: assert ({cout, sum} == {a, cin});
    end
    if (b == '0 && !cin) begin
      a_r6_identity: assert (sum == a && !cout);
    end
  end

endmodule

bind cla_tree_adder cla_tree_adder_chk #(.W(W)) u_chk (
  .a(a), .b(b), .cin(cin), .sum(sum), .cout(cout)
);

// File: tb/tb_cla_tree_adder.sv
`timescale 1ns/1ps
module tb_cla_tree_adder;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [15:0] a16 = '0, b16 = '0, s16;
  logic [31:0] a32 = '0, b32 = '0, s32;
  logic [63:0] a64 = '0, b64 = '0, s64;
  logic [5:0]  a6  = '0, b6  = '0, s6;
  logic c16 = 1'b0, c32 = 1'b0, c64 = 1'b0, c6 = 1'b0;
  logic o16, o32, o64, o6;

  cla_tree_adder dut (.a(a16), .b(b16), .cin(c16), .sum(s16), .cout(o16));
  cla_tree_adder #(.W(32)) dut_w32 (.a(a32), .b(b32), .cin(c32), .sum(s32), .cout(o32));
  cla_tree_adder #(.W(64)) dut_w64 (.a(a64), .b(b64), .cin(c64), .sum(s64), .cout(o64));
  cla_tree_adder #(.W(6))  dut_w6  (.a(a6),  .b(b6),  .cin(c6),  .sum(s6),  .cout(o6));

  function automatic logic [64:0] model(int w, logic [63:0] x, logic [63:0] y, logic c);
    logic [64:0] m, m2, t;
    m  = (65'd1 << w) - 65'd1;
    m2 = (65'd1 << (w + 1)) - 65'd1;
    t  = ({1'b0, x} & m) + ({1'b0, y} & m) + {64'd0, c};
    return t & m2;
  endfunction

  task automatic check(string r, int w, logic [64:0] act, logic [64:0] exp);
    logic [64:0] m;
    m = (65'd1 << w) - 65'd1;
    checks++;
    if ((act & m) != (exp & m)) begin
      errors++;
      $display("FAIL %s sum W=%0d actual=%h expected=%h", r, w, act & m, exp & m);
    end
    checks++;
    if (act[w] != exp[w]) begin
      errors++;
      $display("FAIL %s cout W=%0d actual=%b expected=%b", r, w, act[w], exp[w]);
    end
  endtask

  task automatic step(logic [63:0] x, logic [63:0] y, logic c, string r);
    @(posedge clk);
    a16 <= x[15:0]; b16 <= y[15:0]; c16 <= c;
    a32 <= x[31:0]; b32 <= y[31:0]; c32 <= c;
    a64 <= x;       b64 <= y;       c64 <= c;
    a6  <= x[5:0];  b6  <= y[5:0];  c6  <= c;
    @(negedge clk);
    check(r, 16, {48'd0, o16, s16}, model(16, x, y, c));
    check(r, 32, {32'd0, o32, s32}, model(32, x, y, c));
    check(r, 64, {o64, s64},        model(64, x, y, c));
    check(r, 6,  {58'd0, o6, s6},   model(6,  x, y, c));
  endtask

  function automatic logic [63:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired after %0d cycles", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [63:0] x, y;
    @(negedge clk);
    // R6: idle state with all-zero inputs
    check("R6", 16, {48'd0, o16, s16}, 65'd0);
    step('0, '0, 1'b0, "R6");
    step('1, '0, 1'b1, "R3");
    step('1, 64'd1, 1'b0, "R2");
    step('1, '0, 1'b0, "R4");
    step(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b0, "R4");
    step(64'h5555_5555_5555_5555, 64'hAAAA_AAAA_AAAA_AAAA, 1'b1, "R4");
    step('1, '1, 1'b1, "R5");
    step(64'h0F0F_0F0F_0F0F_0F0F, 64'h0101_0101_0101_0101, 1'b0, "R1");
    step(64'h8000_8000_8000_8000, 64'h8000_8000_8000_8000, 1'b1, "R7");
    step(64'h7FFF_FFFF_7FFF_FFFF, 64'h0000_0001_0000_0001, 1'b0, "R7");
    for (int i = 0; i < 200; i++) begin
      x = rnd64();
      step(x, '0, 1'b1, "R3");
      step(x, '0, 1'b0, "R6");
      step(x, x, i[0], "R5");
      step(x, ~x, i[1], "R4");
    end
    // R7: exhaustive over the 6-bit instance, random for the wider ones
    for (int i = 0; i < 8192; i++) begin
      x = rnd64(); y = rnd64();
      x[5:0] = i[5:0];
      y[5:0] = i[11:6];
      step(x, y, i[12], "R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule